// File: doc/BRIEF.md
# I2C Master Channel Status and Error Flags

This block holds the status and error flags of one single-master I2C controller channel. The transfer engine sends it single-cycle event pulses: a transfer command has finished, a NACK came back, a start-condition error, a stop-condition error, and two kinds of mismatch error. It also sends two levels. One says the local controller owns the bus. The other says the bus is busy. The block turns these into sticky flags and presents them as two read-only bytes, a status byte and an error byte, for a register bus to read.

Software drives the flags through two inputs. A 3-bit transfer command write clears the completion flag whatever the code is. The error flags clear only on the two dedicated codes, 000 and 111. A software-reset strobe clears every flag at once. The status bytes have no write path at all.

Top module: `i2cFlagTop`

## Requirements
- R1: `statusByte` has the local-bus-use flag at bit 3, the bus-busy flag at bit 2, the summary error flag at bit 1 and the command-complete flag at bit 0; bits 7:4 read 0.
- R2: `errByte` has the NACK flag at bit 4, start error at bit 3, stop error at bit 2, mismatch A at bit 1 and mismatch B at bit 0; bits 7:5 read 0.
- R3: Each error flag reads 1 from the clock edge that samples its event pulse, and it stays 1 until a clearing action.
- R4: The summary error flag is 1 exactly when at least one of the five error flags is 1.
- R5: A command write with code 000 or 111 clears all five error flags on the next edge. Any other code leaves them unchanged.
- R6: The command-complete flag sets on the edge that samples `xferDone`. A command write with any code clears it. It reads 0 while idle and while a command is pending.
- R7: If an event pulse and a command write that would clear its flag arrive in the same cycle, the flag is 1 after the edge.
- R8: `swReset` clears all flags in both bytes on the next edge, and it overrides any event in the same cycle.
- R9: The local-bus-use and bus-busy flags show `localBusy` and `busBusy` one clock after they are sampled.
- R10: While `rstN` is low, both bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| cmdWrEn | input | 1 | Strobe for a transfer command write |
| cmdCode | input | 3 | Transfer command code that is written |
| swReset | input | 1 | Software reset strobe |
| xferDone | input | 1 | Pulse: transfer command completed |
| nackEvt | input | 1 | Pulse: NACK received |
| startErrEvt | input | 1 | Pulse: start condition error |
| stopErrEvt | input | 1 | Pulse: stop condition error |
| misAEvt | input | 1 | Pulse: first mismatch error |
| misBEvt | input | 1 | Pulse: second mismatch error |
| localBusy | input | 1 | Level: local controller is using the bus |
| busBusy | input | 1 | Level: bus is occupied |
| statusByte | output | 8 | Read-only status byte |
| errByte | output | 8 | Read-only error status byte |

## Verification
Assertions check several rules on every cycle: that flags are sticky unless a clearing strobe arrives, that a pending event beats a command clear, that a software reset leaves both bytes at zero, that any command write drops the completion flag, that non-clearing codes keep the NACK flag, and that the unused bits stay zero. Other properties can only be shown by the directed scenarios. These are the exact bit position of each source in the two bytes, the summary bit following the OR of the error flags as they build up and clear, and the one-cycle delay from the busy levels to the status bits.

// File: rtl/i2cFlagPkg.sv
package i2cFlagPkg;
  // Strobes from command decode to the flag registers
  typedef struct packed {
    logic clrDone;  // any command write
    logic clrErr;   // error-clearing command code
    logic clrAll;   // software reset
  } flagStrobeT;
endpackage

// File: rtl/i2cFlagCtrl.sv
module i2cFlagCtrl
  import i2cFlagPkg::*;
#(
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] CLR_CODE_A = '0,
  parameter logic [CMD_W-1:0] CLR_CODE_B = '1
) (
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             swReset,
  output flagStrobeT       strobes
);
  logic isClrCode;

  always_comb begin
    isClrCode       = (cmdCode == CLR_CODE_A) || (cmdCode == CLR_CODE_B);
    strobes.clrAll  = swReset;
    strobes.clrDone = cmdWrEn;
    strobes.clrErr  = cmdWrEn && isClrCode;
  end
endmodule

// File: rtl/i2cFlagPath.sv
module i2cFlagPath
  import i2cFlagPkg::*;
#(
  parameter int N_ERR = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  flagStrobeT       strobes,
  input  logic [N_ERR-1:0] errEvt,
  input  logic             xferDone,
  input  logic             localBusy,
  input  logic             busBusy,
  output logic [N_ERR-1:0] errFlags,
  output logic             doneFlag,
  output logic             localFlag,
  output logic             busyFlag
);
  // Sticky error flags: software reset first, then set, then clear
  for (genvar i = 0; i < N_ERR; i++) begin : gErr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                errFlags[i] <= 1'b0;
      else if (strobes.clrAll)  errFlags[i] <= 1'b0;
      else if (errEvt[i])       errFlags[i] <= 1'b1;
      else if (strobes.clrErr)  errFlags[i] <= 1'b0;
    end

    // R3: flag holds without a clearing strobe
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
      errFlags[i] && !strobes.clrErr && !strobes.clrAll |=> errFlags[i]);
    // R7: event beats command clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      errEvt[i] && !strobes.clrAll |=> errFlags[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                doneFlag <= 1'b0;
    else if (strobes.clrAll)  doneFlag <= 1'b0;
    else if (xferDone)        doneFlag <= 1'b1;
    else if (strobes.clrDone) doneFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      localFlag <= 1'b0;
      busyFlag  <= 1'b0;
    end else begin
      localFlag <= localBusy && !strobes.clrAll;
      busyFlag  <= busBusy && !strobes.clrAll;
    end
  end

  // R6: a command write without completion drops the done flag
  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrDone && !xferDone |=> !doneFlag);
endmodule

// File: rtl/i2cFlagTop.sv
module i2cFlagTop
  import i2cFlagPkg::*;
#(
  parameter int CMD_W  = 3,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             swReset,
  input  logic             xferDone,
  input  logic             nackEvt,
  input  logic             startErrEvt,
  input  logic             stopErrEvt,
  input  logic             misAEvt,
  input  logic             misBEvt,
  input  logic             localBusy,
  input  logic             busBusy,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] errByte
);
  localparam int N_ERR = 5;
  localparam int ST_W  = 4;

  flagStrobeT       strobes;
  logic [N_ERR-1:0] errFlags;
  logic             doneFlag, localFlag, busyFlag;

  i2cFlagCtrl #(.CMD_W(CMD_W)) u_ctrl (
    .cmdWrEn (cmdWrEn),
    .cmdCode (cmdCode),
    .swReset (swReset),
    .strobes (strobes)
  );

  i2cFlagPath #(.N_ERR(N_ERR)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .errEvt    ({nackEvt, startErrEvt, stopErrEvt, misAEvt, misBEvt}),
    .xferDone  (xferDone),
    .localBusy (localBusy),
    .busBusy   (busBusy),
    .errFlags  (errFlags),
    .doneFlag  (doneFlag),
    .localFlag (localFlag),
    .busyFlag  (busyFlag)
  );

  always_comb begin
    statusByte = '0;
    statusByte[ST_W-1:0] = {localFlag, busyFlag, |errFlags, doneFlag};
    errByte = '0;
    errByte[N_ERR-1:0] = errFlags;
  end

  // R8: software reset empties both bytes
  assert_swreset_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (statusByte == '0) && (errByte == '0));
  // R5: non-clearing code keeps the NACK flag
  assert_keep_nack_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn && cmdCode != 3'b000 && cmdCode != 3'b111 && !swReset && errByte[4]
    |=> errByte[4]);
  // R1 R2: unused bits stay zero
  always_comb begin
    assert_spare_zero_R1: assert (statusByte[BYTE_W-1:ST_W] == '0);
    assert_spare_zero_R2: assert (errByte[BYTE_W-1:N_ERR] == '0);
  end
endmodule

// File: tb/i2cFlagTop_tb.sv
module i2cFlagTop_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrEn = 0, swReset = 0, xferDone = 0;
  logic [2:0] cmdCode = '0;
  logic nackEvt = 0, startErrEvt = 0, stopErrEvt = 0, misAEvt = 0, misBEvt = 0;
  logic localBusy = 0, busBusy = 0;
  logic [7:0] statusByte, errByte;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cFlagTop u_dut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdCode(cmdCode),
    .swReset(swReset), .xferDone(xferDone), .nackEvt(nackEvt),
    .startErrEvt(startErrEvt), .stopErrEvt(stopErrEvt), .misAEvt(misAEvt),
    .misBEvt(misBEvt), .localBusy(localBusy), .busBusy(busBusy),
    .statusByte(statusByte), .errByte(errByte)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // Apply drives for one cycle, return at the next falling edge
  task automatic idleCycle();
    @(negedge clk);
    cmdWrEn = 0; swReset = 0; xferDone = 0;
    nackEvt = 0; startErrEvt = 0; stopErrEvt = 0; misAEvt = 0; misBEvt = 0;
  endtask

  task automatic writeCmd(logic [2:0] code);
    cmdWrEn = 1; cmdCode = code;
    idleCycle();
  endtask

  task automatic testReset();
    check("R10 status", statusByte, 8'h00);
    check("R10 err", errByte, 8'h00);
    @(negedge clk); rstN = 1;
    idleCycle();
    check("R10 after release", statusByte, 8'h00);
  endtask

  task automatic testLevels();
    localBusy = 1; busBusy = 0;
    check("R9 not yet sampled", statusByte, 8'h00);
    idleCycle();
    check("R1 R9 local bit3", statusByte, 8'h08);
    localBusy = 0; busBusy = 1;
    idleCycle();
    check("R1 R9 busy bit2", statusByte, 8'h04);
    busBusy = 0;
    idleCycle();
    check("R9 levels low", statusByte, 8'h00);
  endtask

  task automatic testErrors();
    nackEvt = 1; idleCycle();
    check("R2 R3 nack bit4", errByte, 8'h10);
    check("R1 R4 summary bit1", statusByte, 8'h02);
    idleCycle(); idleCycle();
    check("R3 nack sticky", errByte, 8'h10);
    startErrEvt = 1; idleCycle();
    stopErrEvt = 1; idleCycle();
    misAEvt = 1; idleCycle();
    misBEvt = 1; idleCycle();
    check("R2 all five", errByte, 8'h1F);
    writeCmd(3'b011);
    check("R5 code 011 keeps", errByte, 8'h1F);
    writeCmd(3'b000);
    check("R5 code 000 clears", errByte, 8'h00);
    check("R4 summary low", statusByte, 8'h00);
    misBEvt = 1; idleCycle();
    check("R4 single source summary", statusByte, 8'h02);
    writeCmd(3'b110);
    check("R5 code 110 keeps", errByte, 8'h01);
    writeCmd(3'b111);
    check("R5 code 111 clears", errByte, 8'h00);
  endtask

  task automatic testDone();
    writeCmd(3'b010);
    check("R6 pending reads 0", statusByte, 8'h00);
    xferDone = 1; idleCycle();
    check("R6 done sets", statusByte, 8'h01);
    idleCycle();
    check("R6 done holds", statusByte, 8'h01);
    writeCmd(3'b101);
    check("R6 any write clears", statusByte, 8'h00);
  endtask

  task automatic testCollision();
    stopErrEvt = 1; cmdWrEn = 1; cmdCode = 3'b000; idleCycle();
    check("R7 event beats clear", errByte, 8'h04);
    xferDone = 1; cmdWrEn = 1; cmdCode = 3'b100; idleCycle();
    check("R7 done beats write", statusByte, 8'h03);
    writeCmd(3'b111);
    check("R5 cleanup", errByte, 8'h00);
  endtask

  task automatic testSwReset();
    localBusy = 1; busBusy = 1; nackEvt = 1; xferDone = 1; idleCycle();
    check("R8 setup", statusByte, 8'h0F);
    swReset = 1; startErrEvt = 1; xferDone = 1; idleCycle();
    check("R8 status cleared", statusByte, 8'h00);
    check("R8 err cleared", errByte, 8'h00);
    idleCycle();
    check("R9 levels return", statusByte, 8'h0C);
    localBusy = 0; busBusy = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    testReset();
    testLevels();
    testErrors();
    testDone();
    testCollision();
    testSwReset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule